// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block brings a storage-interface PHY out of power-down in a fixed order. It drives the analog controls: power-down-bar, DLL enable, DLL frequency code, drive-type code, and the output tap-delay enable and select. It watches two status lines from the analog side, calibration complete and DLL locked. All waits come from one microsecond timer. The `CLK_PER_US` parameter sets the number of system clock cycles in a microsecond.

A power-on request does the following, in order. It loads the fixed pad settings and holds the PHY in power-down for a settle period. It then releases power-down and waits for calibration to finish, with a short timeout. Next it applies the frequency code taken from the card clock rate, enables the DLL, and waits for lock with a long timeout. A power-off request only pulls power-down-bar low, and it completes at once.

The card clock rate comes in as a binary value in hertz. Comparators map it to the nearest multiple of 50 MHz and clamp the result to codes 0 to 3. A rate beyond that range sets a warning flag, and the sequence still continues.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset these outputs are all 0: pdb_o, dll_en_o, fsel_o, drv_type_o, otap_en_o, otap_sel_o, busy_o, done_o, err_cal_o, err_dll_o and rate_warn_o.
- R2: In the cycle after a power-on request is accepted in idle, the outputs are: drv_type_o=6, otap_en_o=0, otap_sel_o=4, pdb_o=0, dll_en_o=0, busy_o=1, and done and both error flags are cleared.
- R3: A power-off request in idle (with no power-on request) sets pdb_o=0 and done_o=1 in the next cycle. dll_en_o, fsel_o and drv_type_o keep their values.
- R4: fsel_o is 0 for rate <25 MHz, 1 for 25 MHz to <75 MHz, 2 for 75 MHz to <125 MHz, and 3 at 125 MHz or above. A rate exactly on a boundary takes the higher code. This is the rate divided by 50 MHz, rounded half up and clamped to 3.
- R5: rate_warn_o is set when the rounded quotient exceeds 3 (rate ≥175 MHz). It is captured at power-on and holds until the next accepted request.
- R6: pdb_o stays low for exactly SETTLE_US*CLK_PER_US+1 cycles in which busy_o is high, then rises.
- R7: fsel_o does not change before calibration complete is seen. The new code is on fsel_o before dll_en_o rises. dll_en_o rises only while pdb_o is high.
- R8: If calibration complete never arrives, err_cal_o rises after exactly CAL_TMO_US*CLK_PER_US+1 cycles with pdb_o high. busy_o then drops, dll_en_o stays 0 and fsel_o is unchanged.
- R9: If DLL lock never arrives, err_dll_o rises after exactly DLL_TMO_US*CLK_PER_US+1 cycles with dll_en_o high. busy_o then drops.
- R10: When DLL lock is seen, done_o rises and busy_o drops. At most one of done_o, err_cal_o and err_dll_o is high.
- R11: Result flags and fsel_o hold while idle until the next request. Requests made while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_req_i | input | 1 | Start the power-up sequence (one-cycle pulse) |
| pwr_off_req_i | input | 1 | Power down the PHY (one-cycle pulse) |
| clk_rate_hz_i | input | RATE_W | Card clock rate in hertz |
| cal_done_i | input | 1 | Calibration complete from the PHY |
| dll_rdy_i | input | 1 | DLL locked from the PHY |
| pdb_o | output | 1 | Power-down-bar to the PHY |
| dll_en_o | output | 1 | DLL enable |
| fsel_o | output | 3 | DLL frequency code |
| drv_type_o | output | 3 | Drive strength code |
| otap_en_o | output | 1 | Output tap-delay enable |
| otap_sel_o | output | 4 | Output tap-delay select |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last request completed |
| err_cal_o | output | 1 | Calibration timeout |
| err_dll_o | output | 1 | DLL lock timeout |
| rate_warn_o | output | 1 | Clock rate above supported range |

## Verification
Most wrong internal states show up as a cycle-count error. A timer cleared on the wrong edge, or a compare off by one, changes the exact number of cycles that power-down-bar is held low. It also changes how long the block waits before flagging a timeout. The testbench measures both counts on every sequence. A wrong rate threshold shows up as a wrong frequency code once calibration completes. A state that skips calibration raises the DLL enable early, while the frequency code still holds its old value. A state that fails to return to idle leaves busy high, so the next request is lost and the watchdog expires.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CAL    = 3'd2,
    ST_FSEL   = 3'd3,
    ST_DLL    = 3'd4
  } seq_state_e;

  localparam int unsigned FSEL_W     = 3;
  localparam int unsigned DRV_W      = 3;
  localparam int unsigned OTAP_W     = 4;
  localparam logic [DRV_W-1:0]  DRV_50OHM     = 3'd6;
  localparam logic [OTAP_W-1:0] OTAP_SEL_INIT = 4'd4;
endpackage

// File: rtl/pwrup_us_timer.sv
module pwrup_us_timer #(
  parameter int unsigned CLK_PER_US = 200,
  parameter int unsigned US_W       = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic [US_W-1:0] us_o
);
  logic tick;

  generate
    if (CLK_PER_US > 1) begin : g_pre
      localparam int unsigned PRE_W = $clog2(CLK_PER_US);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
      logic [PRE_W-1:0] pre_q;
      assign tick = (pre_q == PRE_LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (clr_i)  pre_q <= '0;
        else if (tick)   pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     us_o <= '0;
    else if (clr_i)  us_o <= '0;
    else if (tick)   us_o <= us_o + 1'b1;
  end
endmodule

// File: rtl/pwrup_rate_map.sv
module pwrup_rate_map
  import pwrup_pkg::*;
#(
  parameter int unsigned     RATE_W = 32,
  parameter longint unsigned REF_HZ = 64'd50_000_000
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [FSEL_W-1:0] code_o,
  output logic              warn_o
);
  localparam int unsigned NTHR = 4;
  logic [NTHR-1:0] ge;
  logic [63:0]     rate_w;

  assign rate_w = 64'(rate_i);

  // thresholds at odd multiples of REF_HZ/2; equality rounds up
  generate
    for (genvar g = 0; g < NTHR; g++) begin : g_thr
      localparam longint unsigned THR = (longint'(2 * g + 1) * REF_HZ) / 2;
      assign ge[g] = (rate_w >= THR);
    end
  endgenerate

  always_comb begin
    if (ge[2])      code_o = FSEL_W'(3);
    else if (ge[1]) code_o = FSEL_W'(2);
    else if (ge[0]) code_o = FSEL_W'(1);
    else            code_o = FSEL_W'(0);
  end

  assign warn_o = ge[3];
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned     CLK_PER_US = 200,
  parameter int unsigned     SETTLE_US  = 5,
  parameter int unsigned     CAL_TMO_US = 50,
  parameter int unsigned     DLL_TMO_US = 50_000,
  parameter int unsigned     RATE_W     = 32,
  parameter longint unsigned REF_HZ     = 64'd50_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_req_i,
  input  logic              pwr_off_req_i,
  input  logic [RATE_W-1:0] clk_rate_hz_i,
  input  logic              cal_done_i,
  input  logic              dll_rdy_i,
  output logic              pdb_o,
  output logic              dll_en_o,
  output logic [2:0]        fsel_o,
  output logic [2:0]        drv_type_o,
  output logic              otap_en_o,
  output logic [3:0]        otap_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_cal_o,
  output logic              err_dll_o,
  output logic              rate_warn_o
);
  localparam int unsigned MAX_A  = (CAL_TMO_US > SETTLE_US) ? CAL_TMO_US : SETTLE_US;
  localparam int unsigned MAX_US = (DLL_TMO_US > MAX_A) ? DLL_TMO_US : MAX_A;
  localparam int unsigned US_W   = $clog2(MAX_US + 1);

  seq_state_e        state_q, state_d;
  logic [US_W-1:0]   us_cnt;
  logic              timer_clr;
  logic [FSEL_W-1:0] rate_code, code_q;
  logic              rate_warn;
  logic              settle_hit, cal_tmo, dll_tmo;

  pwrup_rate_map #(.RATE_W(RATE_W), .REF_HZ(REF_HZ)) u_rate_map (
    .rate_i (clk_rate_hz_i),
    .code_o (rate_code),
    .warn_o (rate_warn)
  );

  pwrup_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (timer_clr),
    .us_o   (us_cnt)
  );

  assign settle_hit = (us_cnt == US_W'(SETTLE_US));
  assign cal_tmo    = (us_cnt == US_W'(CAL_TMO_US));
  assign dll_tmo    = (us_cnt == US_W'(DLL_TMO_US));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (pwr_on_req_i) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_hit) state_d = ST_CAL;
      ST_CAL:    if (cal_done_i || cal_tmo) state_d = cal_done_i ? ST_FSEL : ST_IDLE;
      ST_FSEL:   state_d = ST_DLL;
      ST_DLL:    if (dll_rdy_i || dll_tmo) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // timer restarts on every stage entry
  assign timer_clr = (state_q == ST_IDLE) || (state_d != state_q);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pdb_o       <= 1'b0;
      dll_en_o    <= 1'b0;
      fsel_o      <= '0;
      drv_type_o  <= '0;
      otap_en_o   <= 1'b0;
      otap_sel_o  <= '0;
      done_o      <= 1'b0;
      err_cal_o   <= 1'b0;
      err_dll_o   <= 1'b0;
      rate_warn_o <= 1'b0;
      code_q      <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: begin
          if (pwr_on_req_i) begin
            drv_type_o  <= DRV_50OHM;
            otap_en_o   <= 1'b0;
            otap_sel_o  <= OTAP_SEL_INIT;
            pdb_o       <= 1'b0;
            dll_en_o    <= 1'b0;
            code_q      <= rate_code;
            rate_warn_o <= rate_warn;
            done_o      <= 1'b0;
            err_cal_o   <= 1'b0;
            err_dll_o   <= 1'b0;
          end else if (pwr_off_req_i) begin
            pdb_o       <= 1'b0;
            done_o      <= 1'b1;
            err_cal_o   <= 1'b0;
            err_dll_o   <= 1'b0;
            rate_warn_o <= 1'b0;
          end
        end
        ST_SETTLE: if (settle_hit) pdb_o <= 1'b1;
        ST_CAL: begin
          if (cal_done_i)   fsel_o    <= code_q;
          else if (cal_tmo) err_cal_o <= 1'b1;
        end
        ST_FSEL: dll_en_o <= 1'b1;
        ST_DLL: begin
          if (dll_rdy_i)    done_o    <= 1'b1;
          else if (dll_tmo) err_dll_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_on_req_i,
  input logic       pwr_off_req_i,
  input logic       pdb_o,
  input logic       dll_en_o,
  input logic [2:0] fsel_o,
  input logic [2:0] drv_type_o,
  input logic       otap_en_o,
  input logic [3:0] otap_sel_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_cal_o,
  input logic       err_dll_o,
  input logic       rate_warn_o
);
  a_r2_start_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pwr_on_req_i) |=> (busy_o && !pdb_o && !dll_en_o && drv_type_o == 3'd6
      && !otap_en_o && otap_sel_o == 4'd4 && !done_o && !err_cal_o && !err_dll_o));

  a_r3_off_only_pdb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !pwr_on_req_i && pwr_off_req_i) |=>
      (!pdb_o && done_o && $stable(dll_en_o) && $stable(fsel_o) && $stable(drv_type_o)));

  a_r5_warn_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rate_warn_o));

  a_r7_fsel_frozen_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pdb_o) |=> $stable(fsel_o));

  a_r7_dll_needs_pdb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dll_en_o) |-> (pdb_o && busy_o));

  a_r8_cal_err_no_dll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_cal_o) |-> (!dll_en_o && pdb_o && !busy_o));

  a_r9_dll_err_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_dll_o) |-> (dll_en_o && pdb_o && !busy_o));

  a_r10_onehot_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_cal_o, err_dll_o}));

  a_r11_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !pwr_on_req_i && !pwr_off_req_i) |=>
      $stable({done_o, err_cal_o, err_dll_o, rate_warn_o, fsel_o}));
endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_on_req_i (pwr_on_req_i),
  .pwr_off_req_i(pwr_off_req_i),
  .pdb_o        (pdb_o),
  .dll_en_o     (dll_en_o),
  .fsel_o       (fsel_o),
  .drv_type_o   (drv_type_o),
  .otap_en_o    (otap_en_o),
  .otap_sel_o   (otap_sel_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_cal_o    (err_cal_o),
  .err_dll_o    (err_dll_o),
  .rate_warn_o  (rate_warn_o)
);

// File: tb/phy_pwrup_seq_tb.sv
`timescale 1ns/1ps
module phy_pwrup_seq_tb;
  localparam int unsigned CPU   = 4;
  localparam int unsigned SET   = 5;
  localparam int unsigned CTMO  = 50;
  localparam int unsigned DTMO  = 100;
  localparam int unsigned NEVER = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0;
  logic [31:0] rate = '0;
  logic cal_done, dll_rdy;
  logic pdb, dll_en, otap_en, busy, done, err_cal, err_dll, warn;
  logic [2:0] fsel, drv;
  logic [3:0] otap_sel;

  int unsigned cal_lat = NEVER, dll_lat = NEVER;
  int unsigned cal_cnt, dll_cnt;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  phy_pwrup_seq #(.CLK_PER_US(CPU), .SETTLE_US(SET), .CAL_TMO_US(CTMO), .DLL_TMO_US(DTMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_req_i(on_req), .pwr_off_req_i(off_req),
    .clk_rate_hz_i(rate), .cal_done_i(cal_done), .dll_rdy_i(dll_rdy),
    .pdb_o(pdb), .dll_en_o(dll_en), .fsel_o(fsel), .drv_type_o(drv),
    .otap_en_o(otap_en), .otap_sel_o(otap_sel), .busy_o(busy), .done_o(done),
    .err_cal_o(err_cal), .err_dll_o(err_dll), .rate_warn_o(warn)
  );

  // analog models: delayed status after enable
  always_ff @(posedge clk) begin
    cal_cnt <= pdb ? cal_cnt + 1 : 0;
    dll_cnt <= (pdb && dll_en) ? dll_cnt + 1 : 0;
  end
  assign cal_done = pdb && (cal_cnt >= cal_lat);
  assign dll_rdy  = pdb && dll_en && (dll_cnt >= dll_lat);

  function automatic int unsigned exp_q(input logic [31:0] r);
    return int'((longint'(r) + 64'd25_000_000) / 64'd50_000_000);
  endfunction
  function automatic logic [2:0] exp_code(input logic [31:0] r);
    return (exp_q(r) > 3) ? 3'd3 : 3'(exp_q(r));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_on(input logic [31:0] r, input int unsigned cl, input int unsigned dl, input bit poke);
    logic [2:0] prev_fsel;
    int settle, calw, dllw;
    bit dll_seen;
    prev_fsel = fsel;
    cal_lat = cl; dll_lat = dl;
    @(negedge clk); rate = r; on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    check(busy && !pdb && !dll_en, "R2 busy/pdb/dll_en", {busy, pdb, dll_en}, 3'b100);
    check(drv == 3'd6, "R2 drv_type", drv, 6);
    check(!otap_en && otap_sel == 4'd4, "R2 otap", {otap_en, otap_sel}, 4);
    check(!done && !err_cal && !err_dll, "R2 results cleared", {done, err_cal, err_dll}, 0);
    settle = 1; calw = 0; dllw = 0; dll_seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      off_req = 1'b0; on_req = 1'b0;
      if (!busy) break;
      if (!pdb) settle++;
      else if (!dll_en) calw++;
      else dllw++;
      if (!dll_en && !cal_done)
        check(fsel == prev_fsel, "R7 fsel before cal", fsel, prev_fsel);
      if (dll_en && !dll_seen) begin
        dll_seen = 1;
        check(fsel == exp_code(r), "R7 fsel set before dll_en", fsel, exp_code(r));
        if (poke) begin off_req = 1'b1; on_req = 1'b1; end
      end
    end
    check(!busy, "R11 sequence ended", busy, 0);
    check(settle == SET * CPU + 1, "R6 settle cycles", settle, SET * CPU + 1);
    check(warn == (exp_q(r) > 3), "R5 warn", warn, exp_q(r) > 3);
    if (cl == NEVER) begin
      check(err_cal && !done && !err_dll, "R8 cal error", {done, err_cal, err_dll}, 3'b010);
      check(calw == CTMO * CPU + 1, "R8 cal timeout cycles", calw, CTMO * CPU + 1);
      check(!dll_en && fsel == prev_fsel, "R8 no dll/fsel", {dll_en, fsel}, {1'b0, prev_fsel});
    end else if (dl == NEVER) begin
      check(err_dll && !done && !err_cal, "R9 dll error", {done, err_cal, err_dll}, 3'b001);
      check(dllw == DTMO * CPU + 1, "R9 dll timeout cycles", dllw, DTMO * CPU + 1);
    end else begin
      check(done && !err_cal && !err_dll, "R10 done", {done, err_cal, err_dll}, 3'b100);
      check(fsel == exp_code(r), "R4 fsel code", fsel, exp_code(r));
      check(pdb && dll_en, "R11 busy request ignored", {pdb, dll_en}, 2'b11);
    end
    begin
      logic [6:0] snap;
      snap = {done, err_cal, err_dll, warn, fsel};
      repeat (10) @(negedge clk);
      check({done, err_cal, err_dll, warn, fsel} == snap, "R11 results hold",
            {done, err_cal, err_dll, warn, fsel}, snap);
    end
  endtask

  task automatic run_off();
    logic d_en; logic [2:0] f, dv;
    d_en = dll_en; f = fsel; dv = drv;
    @(negedge clk); off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
    check(!pdb && done && !busy, "R3 off pdb/done", {pdb, done, busy}, 3'b010);
    check(dll_en == d_en && fsel == f && drv == dv, "R3 others unchanged",
          {dll_en, fsel, drv}, {d_en, f, dv});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] dir_rates [9];
    dir_rates = '{32'd0, 32'd24_999_999, 32'd25_000_000, 32'd74_999_999, 32'd75_000_000,
                  32'd125_000_000, 32'd174_999_999, 32'd175_000_000, 32'd200_000_000};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check({pdb, dll_en, fsel, drv, otap_en, otap_sel, busy, done, err_cal, err_dll, warn} == 0,
          "R1 reset state", {pdb, dll_en, fsel, drv, otap_en, otap_sel, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_on(32'd50_000_000, 10, 40, 0);
    run_off();
    run_on(32'd100_000_000, NEVER, 5, 0);
    run_on(32'd150_000_000, 7, NEVER, 0);
    run_off();
    run_on(32'd75_000_000, 3, 20, 1);
    foreach (dir_rates[k]) run_on(dir_rates[k], 1 + k, 2 + 3 * k, 0);
    for (int n = 0; n < 16; n++) begin
      logic [31:0] rr;
      rr = $urandom % 250_000_000;
      run_on(rr, 1 + ($urandom % 150), 1 + ($urandom % 350), n[0]);
      if (n % 5 == 0) run_off();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule